// File: doc/BRIEF.md
# Host-Bus Transfer Timing Sequencer

This block runs single read and write cycles on an 8-bit host bus for one chip-select. An internal client raises a request carrying direction, a burst flag and write data. The sequencer then drives the active-low read or write strobe for a programmed number of clocks. It returns a one-clock acknowledge, with the captured read data, once the strobe ends. Between transfers it holds every strobe high for a programmed gap.

Cycle timing comes from static configuration inputs:
- separate read and write wait-state counts;
- a write trim bit that removes one write wait state, except for burst transfers;
- a gap code;
- a ready-delay code.

An active-low ready input from the target is sampled on every rising edge. A low sample freezes the strobe a programmed one to three clocks later. The gap and ready-delay codes are captured when a transfer starts. The sequencer acts only while the bus mode input selects the 8-bit host-bus mode (value 2).

The client keeps `req_valid` and its fields steady until it sees `req_ack`. It may present the next request in the same cycle that `req_ack` is high.

Top module: `hb_xfer_seq`

## Requirements
- R1: A transfer starts only while `cfg_mode` equals 2. For any other value, both strobes stay high and `req_ack` stays low, even with `req_valid` held high.
- R2: A read started from idle drives `bus_rd_n` low from the clock edge that samples the request, for `cfg_rd_ws`+1 clocks when not stalled. `bus_wr_n` stays high and `bus_doe` stays low throughout. The write trim bit and the burst flag have no effect on reads.
- R3: A write with `cfg_wr_trim`=0 drives `bus_wr_n` low for `cfg_wr_ws`+1 clocks when not stalled. While it is low, `bus_doe` is 1 and `bus_dout` equals the request's write data.
- R4: A non-burst write with `cfg_wr_trim`=1 and `cfg_wr_ws` nonzero keeps `bus_wr_n` low for `cfg_wr_ws` clocks, one fewer than untrimmed.
- R5: A non-burst write with `cfg_wr_trim`=1 and `cfg_wr_ws`=0 still keeps `bus_wr_n` low for exactly 1 clock; the count does not wrap.
- R6: A burst write (`req_burst`=1) ignores `cfg_wr_trim`, so its strobe lasts `cfg_wr_ws`+1 clocks.
- R7: `req_ack` is high for exactly one clock: the first clock after the final strobe clock. In that cycle `rsp_rdata` holds the value `bus_din` had during the final strobe clock of a read.
- R8: When a request is waiting, the strobes stay high between two transfers for exactly the gap. `cfg_gap_code` 1 gives 1 clock; codes 0, 2 and 3 give 2 clocks.
- R9: If `bus_rdy_n` is sampled low at rising edge E, then the strobe cycle holds at edge E+d. This holds for every stage, including the final one. The strobe stays low and the wait count does not advance. Each such held edge lengthens the strobe by one clock. d is `cfg_rdy_dly` for codes 1 to 3.
- R10: `cfg_rdy_dly` code 0 behaves exactly as code 1.
- R11: Synchronous reset, including one raised in the middle of a transfer, forces both strobes high, `bus_doe` low, `req_ack` low and `rsp_rdata` to 0 from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | Bus mode; the sequencer runs only at value 2 |
| cfg_rd_ws | input | WS_W | Read wait states |
| cfg_wr_ws | input | WS_W | Write wait states before trimming |
| cfg_wr_trim | input | 1 | Remove one write wait state on non-burst writes |
| cfg_gap_code | input | 2 | Inter-transfer gap code (1: one clock, else two) |
| cfg_rdy_dly | input | 2 | Ready stall delay code (0 and 1: one clock, 2, 3) |
| req_valid | input | 1 | Transfer request, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Burst transfer flag |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | DATA_W | Data driven on writes |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | DATA_W | Data returned on reads |
| bus_rdy_n | input | 1 | Target ready, active low stall request |

## Verification
The strobe falls on the same edge that samples the request. The bench raises a request at a falling edge, and the strobe is therefore already low at the next falling edge. From there the bench counts consecutive low samples. The acknowledge and the read data are due at the first falling edge where the strobe reads high again, and both are checked only at that sample.

Ready is changed at falling edge j after the start edge, so rising edge j samples it. By R9, the hold then lands at edge j+d. The bench places that hold inside the strobe or just beyond its unstalled end, and the expected length is what separates one delay from another. For gaps, the bench counts the high samples from the acknowledge cycle up to the next low sample.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;

  // Bus mode value that enables the sequencer
  localparam logic [1:0] MODE_HOSTBUS8 = 2'd2;

  // Code field widths and the longest ready delay they can encode
  localparam int GAP_CODE_W = 2;
  localparam int DLY_CODE_W = 2;
  localparam int MAX_DLY    = (1 << DLY_CODE_W) - 1;

  // Values held in the captured configuration after reset
  localparam logic [GAP_CODE_W-1:0] GAP_CODE_RST = 2'd2;
  localparam logic [DLY_CODE_W-1:0] DLY_CODE_RST = 2'd0;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_GAP    = 2'd2
  } hb_state_e;

  // Idle clocks between transfers; reserved codes fall back to two
  function automatic logic [1:0] gap_cycles(input logic [GAP_CODE_W-1:0] code);
    return (code == 2'd1) ? 2'd1 : 2'd2;
  endfunction

  // Ready pipeline depth; reserved code zero acts as one
  function automatic int unsigned dly_stages(input logic [DLY_CODE_W-1:0] code);
    return (code == '0) ? 1 : int'(code);
  endfunction

endpackage

// File: rtl/hb_timing_decode.sv
module hb_timing_decode #(
  parameter int WS_W = 4
) (
  input  logic            req_write,
  input  logic            req_burst,
  input  logic [WS_W-1:0] rd_ws,
  input  logic [WS_W-1:0] wr_ws,
  input  logic            wr_trim,
  output logic [WS_W-1:0] ws_eff
);

  logic trim_ok;

  // Trim applies to non-burst writes whose count is above zero
  assign trim_ok = wr_trim && !req_burst && (wr_ws != '0);

  always_comb begin
    if (!req_write) begin
      ws_eff = rd_ws;
    end else if (trim_ok) begin
      ws_eff = wr_ws - WS_W'(1);
    end else begin
      ws_eff = wr_ws;
    end
  end

endmodule

// File: rtl/hb_rdy_stall.sv
module hb_rdy_stall
  import hb_seq_pkg::*;
#(
  parameter int DEPTH = MAX_DLY
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rdy_n,
  input  logic [DLY_CODE_W-1:0] dly_code,
  output logic                  stall
);

  // seen_low[k] is the ready-low sample taken k+1 edges ago
  logic [DEPTH-1:0] seen_low;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) seen_low <= '0;
        else     seen_low <= !rdy_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) seen_low <= '0;
        else     seen_low <= {seen_low[DEPTH-2:0], !rdy_n};
      end
    end
  endgenerate

  always_comb begin
    stall = 1'b0;
    for (int k = 1; k <= DEPTH; k++) begin
      if (dly_stages(dly_code) == k) stall = seen_low[k-1];
    end
  end

endmodule

// File: rtl/hb_xfer_fsm.sv
module hb_xfer_fsm
  import hb_seq_pkg::*;
#(
  parameter int WS_W   = 4,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            mode,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [WS_W-1:0]       ws_eff,
  input  logic [GAP_CODE_W-1:0] gap_code,
  input  logic [DLY_CODE_W-1:0] dly_code,
  input  logic                  stall,
  input  logic [DATA_W-1:0]     bus_din,
  output logic [DLY_CODE_W-1:0] dly_code_q,
  output logic                  req_ack,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  bus_rd_n,
  output logic                  bus_wr_n,
  output logic [DATA_W-1:0]     bus_dout,
  output logic                  bus_doe
);

  hb_state_e             state;
  logic [WS_W-1:0]       ws_cnt;
  logic [1:0]            gap_cnt;
  logic [GAP_CODE_W-1:0] gap_code_q;
  logic                  is_wr_q;
  logic                  start_ok;
  logic                  launch;
  logic                  finish;

  assign start_ok = req_valid && (mode == MODE_HOSTBUS8);
  assign launch   = start_ok &&
                    ((state == ST_IDLE) || ((state == ST_GAP) && (gap_cnt == '0)));
  assign finish   = (state == ST_STROBE) && !stall && (ws_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ws_cnt     <= '0;
      gap_cnt    <= '0;
      gap_code_q <= GAP_CODE_RST;
      dly_code_q <= DLY_CODE_RST;
      is_wr_q    <= 1'b0;
      req_ack    <= 1'b0;
      rsp_rdata  <= '0;
      bus_rd_n   <= 1'b1;
      bus_wr_n   <= 1'b1;
      bus_dout   <= '0;
      bus_doe    <= 1'b0;
    end else begin
      req_ack <= 1'b0;
      if (launch) begin
        state      <= ST_STROBE;
        ws_cnt     <= ws_eff;
        gap_code_q <= gap_code;
        dly_code_q <= dly_code;
        is_wr_q    <= req_write;
        bus_rd_n   <= req_write;
        bus_wr_n   <= !req_write;
        bus_doe    <= req_write;
        bus_dout   <= req_wdata;
      end else begin
        case (state)
          ST_STROBE: begin
            if (finish) begin
              state    <= ST_GAP;
              gap_cnt  <= gap_cycles(gap_code_q) - 2'd1;
              req_ack  <= 1'b1;
              bus_rd_n <= 1'b1;
              bus_wr_n <= 1'b1;
              bus_doe  <= 1'b0;
              if (!is_wr_q) rsp_rdata <= bus_din;
            end else if (!stall) begin
              ws_cnt <= ws_cnt - WS_W'(1);
            end
          end
          ST_GAP: begin
            if (gap_cnt != '0) gap_cnt <= gap_cnt - 2'd1;
            else               state   <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/hb_xfer_seq.sv
module hb_xfer_seq
  import hb_seq_pkg::*;
#(
  parameter int WS_W   = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic [WS_W-1:0]   cfg_rd_ws,
  input  logic [WS_W-1:0]   cfg_wr_ws,
  input  logic              cfg_wr_trim,
  input  logic [1:0]        cfg_gap_code,
  input  logic [1:0]        cfg_rdy_dly,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_rdy_n
);

  logic [WS_W-1:0]       ws_eff;
  logic [DLY_CODE_W-1:0] dly_active;
  logic                  stall;

  hb_timing_decode #(.WS_W(WS_W)) u_decode (
    .req_write (req_write),
    .req_burst (req_burst),
    .rd_ws     (cfg_rd_ws),
    .wr_ws     (cfg_wr_ws),
    .wr_trim   (cfg_wr_trim),
    .ws_eff    (ws_eff)
  );

  hb_rdy_stall #(.DEPTH(MAX_DLY)) u_stall (
    .clk      (clk),
    .rst      (rst),
    .rdy_n    (bus_rdy_n),
    .dly_code (dly_active),
    .stall    (stall)
  );

  hb_xfer_fsm #(.WS_W(WS_W), .DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .mode       (cfg_mode),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_wdata  (req_wdata),
    .ws_eff     (ws_eff),
    .gap_code   (cfg_gap_code),
    .dly_code   (cfg_rdy_dly),
    .stall      (stall),
    .bus_din    (bus_din),
    .dly_code_q (dly_active),
    .req_ack    (req_ack),
    .rsp_rdata  (rsp_rdata),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .bus_dout   (bus_dout),
    .bus_doe    (bus_doe)
  );

endmodule

// File: rtl/hb_xfer_seq_chk.sv
module hb_xfer_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg_mode,
  input logic       req_ack,
  input logic       bus_rd_n,
  input logic       bus_wr_n,
  input logic       bus_doe
);

  // R7: completion pulse lasts a single clock
  assert_ack_single_R7: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  // R7: acknowledge follows a strobe clock and sees both strobes released
  assert_ack_after_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> (bus_rd_n && bus_wr_n && (!$past(bus_rd_n) || !$past(bus_wr_n))));

  // R7: every strobe release outside reset comes with the acknowledge
  assert_release_acks_R7: assert property (@(posedge clk) disable iff (rst)
    (($rose(bus_rd_n) || $rose(bus_wr_n)) && !$past(rst)) |-> req_ack);

  // R1: no new cycle begins while the mode is not host-bus 8-bit
  assert_mode_gate_R1: assert property (@(posedge clk) disable iff (rst)
    ((cfg_mode != 2'd2) && bus_rd_n && bus_wr_n) |=> (bus_rd_n && bus_wr_n));

  // R3: the data driver is on only during a write strobe
  assert_oe_on_write_R3: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> (!bus_wr_n && bus_rd_n));

  // R2: the two strobes are never low together
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n));

endmodule

bind hb_xfer_seq hb_xfer_seq_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .cfg_mode (cfg_mode),
  .req_ack  (req_ack),
  .bus_rd_n (bus_rd_n),
  .bus_wr_n (bus_wr_n),
  .bus_doe  (bus_doe)
);

// File: tb/hb_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module hb_xfer_seq_tb_top;

  localparam int WS_W   = 4;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        cfg_mode = 2'd2;
  logic [WS_W-1:0]   cfg_rd_ws = '0;
  logic [WS_W-1:0]   cfg_wr_ws = '0;
  logic              cfg_wr_trim = 1'b0;
  logic [1:0]        cfg_gap_code = 2'd2;
  logic [1:0]        cfg_rdy_dly = 2'd1;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic              req_burst = 1'b0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              req_ack;
  logic [DATA_W-1:0] rsp_rdata;
  logic              bus_rd_n;
  logic              bus_wr_n;
  logic [DATA_W-1:0] bus_dout;
  logic              bus_doe;
  logic [DATA_W-1:0] bus_din = '0;
  logic              bus_rdy_n = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hb_xfer_seq #(.WS_W(WS_W), .DATA_W(DATA_W)) dut_i (.*);

  // Vector fields: [26] write, [25] burst, [24] trim, [23:20] read ws,
  // [19:16] write ws, [15:8] write data, [7:0] read data
  localparam int NVEC = 8;
  localparam logic [26:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 4'd0,  4'd0,  8'h00, 8'hA5},
    {1'b0, 1'b0, 1'b1, 4'd3,  4'd0,  8'h00, 8'h3C},
    {1'b1, 1'b0, 1'b0, 4'd0,  4'd2,  8'h81, 8'h00},
    {1'b1, 1'b0, 1'b1, 4'd0,  4'd2,  8'h42, 8'h00},
    {1'b1, 1'b0, 1'b1, 4'd0,  4'd0,  8'h17, 8'h00},
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd3,  8'hE4, 8'h00},
    {1'b0, 1'b1, 1'b1, 4'd5,  4'd0,  8'h00, 8'h96},
    {1'b1, 1'b0, 1'b1, 4'd0,  4'd15, 8'hC3, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called just after a falling edge; returns at the acknowledge sample
  task automatic run_xfer(input bit wr, input bit burst, input logic [3:0] rdws,
                          input logic [3:0] wrws, input bit trim,
                          input logic [7:0] wd, input logic [7:0] rd,
                          input int rdy_at, input int rdy_len,
                          input int exp_len, input bit keep, input string req);
    int  low  = 0;
    int  j    = 0;
    bit  dok  = 1'b1;
    bit  done = 1'b0;
    cfg_rd_ws   = rdws;
    cfg_wr_ws   = wrws;
    cfg_wr_trim = trim;
    req_write   = wr;
    req_burst   = burst;
    req_wdata   = wd;
    bus_din     = rd;
    req_valid   = 1'b1;
    while (!done && j < 200) begin
      @(negedge clk);
      j++;
      bus_rdy_n = !(rdy_len > 0 && j >= rdy_at && j < rdy_at + rdy_len);
      if (!bus_rd_n || !bus_wr_n) begin
        low++;
        if (wr) begin
          if (!bus_doe || bus_dout !== wd || bus_wr_n) dok = 1'b0;
        end else if (bus_doe || bus_rd_n) begin
          dok = 1'b0;
        end
      end else if (low > 0) begin
        done = 1'b1;
      end
    end
    bus_rdy_n = 1'b1;
    chk(done && low == exp_len, req, "strobe length", low, exp_len);
    chk(req_ack === 1'b1, "R7", "ack after final strobe", int'(req_ack), 1);
    if (wr) chk(dok, "R3", "write data drive", int'(dok), 1);
    else    chk(dok && rsp_rdata === rd, "R7", "read data capture",
                int'(rsp_rdata), int'(rd));
    if (!keep) req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic gap_test(input logic [1:0] code, input int exp_gap, input string req);
    int hc = 1;
    cfg_gap_code = code;
    run_xfer(1'b0, 1'b0, 4'd0, 4'd0, 1'b0, 8'h00, 8'h11, 0, 0, 1, 1'b1, req);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (bus_rd_n && bus_wr_n) hc++;
      else break;
    end
    chk(hc == exp_gap, req, "gap clocks", hc, exp_gap);
    @(negedge clk);
    chk(req_ack === 1'b1, "R7", "ack of chained transfer", int'(req_ack), 1);
    req_valid    = 1'b0;
    cfg_gap_code = 2'd2;
    idle(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run too long actual %0d expected %0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit quiet;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(bus_rd_n && bus_wr_n && !bus_doe && !req_ack && rsp_rdata == '0,
        "R11", "reset outputs", int'({bus_rd_n, bus_wr_n, bus_doe, req_ack}), 12);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [26:0] e;
      int el;
      string tag;
      e = VECS[v];
      if (!e[26]) begin
        el = int'(e[23:20]) + 1;  tag = "R2";
      end else if (e[25]) begin
        el = int'(e[19:16]) + 1;  tag = "R6";
      end else if (e[24] && e[19:16] != 4'd0) begin
        el = int'(e[19:16]);      tag = "R4";
      end else if (e[24]) begin
        el = 1;                   tag = "R5";
      end else begin
        el = int'(e[19:16]) + 1;  tag = "R3";
      end
      run_xfer(e[26], e[25], e[23:20], e[19:16], e[24], e[15:8], e[7:0],
               0, 0, el, 1'b0, tag);
      idle(3);
    end

    // R9 stall delays, read with two wait states
    cfg_rdy_dly = 2'd1;
    run_xfer(1'b0, 1'b0, 4'd2, 4'd0, 1'b0, 8'h00, 8'h5A, 1, 1, 4, 1'b0, "R9"); idle(4);
    cfg_rdy_dly = 2'd3;
    run_xfer(1'b0, 1'b0, 4'd2, 4'd0, 1'b0, 8'h00, 8'h5B, 1, 1, 3, 1'b0, "R9"); idle(4);
    cfg_rdy_dly = 2'd2;
    run_xfer(1'b0, 1'b0, 4'd2, 4'd0, 1'b0, 8'h00, 8'h5C, 1, 1, 4, 1'b0, "R9"); idle(4);
    run_xfer(1'b0, 1'b0, 4'd2, 4'd0, 1'b0, 8'h00, 8'h5D, 2, 1, 3, 1'b0, "R9"); idle(4);
    cfg_rdy_dly = 2'd1;
    run_xfer(1'b1, 1'b0, 4'd0, 4'd2, 1'b0, 8'h6E, 8'h00, 1, 3, 6, 1'b0, "R9"); idle(4);
    // R10 code zero acts as one
    cfg_rdy_dly = 2'd0;
    run_xfer(1'b0, 1'b0, 4'd2, 4'd0, 1'b0, 8'h00, 8'h7F, 2, 1, 4, 1'b0, "R10"); idle(4);
    cfg_rdy_dly = 2'd1;

    // R8 gap codes
    gap_test(2'd1, 1, "R8");
    gap_test(2'd2, 2, "R8");
    gap_test(2'd0, 2, "R8");
    gap_test(2'd3, 2, "R8");

    // R1 other modes never start
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      quiet = 1'b1;
      cfg_mode  = 2'(m);
      cfg_rd_ws = 4'd1;
      req_write = 1'b0;
      req_valid = 1'b1;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (!bus_rd_n || !bus_wr_n || req_ack) quiet = 1'b0;
      end
      chk(quiet, "R1", "idle in other mode", int'(quiet), 1);
      req_valid = 1'b0;
      cfg_mode  = 2'd2;
      idle(2);
    end

    // R11 reset in mid transfer
    cfg_rd_ws = 4'd9;
    req_write = 1'b1;
    req_wdata = 8'h99;
    cfg_wr_ws = 4'd9;
    cfg_wr_trim = 1'b0;
    req_valid = 1'b1;
    idle(3);
    chk(!bus_wr_n, "R11", "transfer under way before reset", int'(bus_wr_n), 0);
    rst = 1'b1;
    req_valid = 1'b0;
    idle(1);
    chk(bus_rd_n && bus_wr_n && !bus_doe && !req_ack && rsp_rdata == '0,
        "R11", "mid-transfer reset", int'({bus_rd_n, bus_wr_n, bus_doe, req_ack}), 12);
    idle(1);
    rst = 1'b0;
    idle(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule